// File: doc/BRIEF.md
# Push-Button Wakeup Deglitcher

This block cleans up a slow, bouncy push-button input so that it can start a power-on sequence. The raw pin is sampled into the local clock domain through a short flop chain. The resulting level is only taken as the new filtered value after it has disagreed with the current filtered value for a fixed number of consecutive millisecond ticks. The default is 32 ticks, which gives 32 ms with a 1 ms tick. A change that does not last that long is discarded, and the disagreement count starts again from zero.

A trigger detector works on the filtered level and raises the wakeup event that starts power-up. A 2-bit runtime select picks one of four trigger kinds. The two edge kinds give a single-clock pulse when the filtered level changes. The two level kinds give an output that stays asserted while the filtered level has the chosen polarity. The filtered level also drives the pull-down enable of an open-drain status pin. The enable is active-low with respect to the level: the pin is pulled low while the filtered level is low.

Top module: `wake_deglitch`

## Requirements
- R1: `level_out` takes the synchronized input value on the rising clock edge that carries the 32nd consecutive `tick_1ms` during which the synchronized input differs from `level_out`, and not on any earlier edge.
- R2: A disagreement that lasts fewer than 32 ticks leaves `level_out` unchanged. The count then restarts, so a later change again needs a full 32 ticks.
- R3: During and right after reset, `level_out` is 0, `stat_pull_en` is 1, and `wake_evt` is 0 when `mode_sel` is 2'b00.
- R4: `stat_pull_en` is always the inverse of `level_out`.
- R5: With `mode_sel` = 2'b00 (rising), `wake_evt` is 1 for exactly the one clock cycle in which `level_out` first reads 1 after reading 0, and 0 otherwise.
- R6: With `mode_sel` = 2'b01 (falling), `wake_evt` is 1 for exactly the one clock cycle in which `level_out` first reads 0 after reading 1, and 0 otherwise.
- R7: With `mode_sel` = 2'b10 (high level), `wake_evt` equals `level_out`.
- R8: With `mode_sel` = 2'b11 (low level), `wake_evt` equals the inverse of `level_out`.
- R9: `raw_in` passes through a two-flop synchronizer before it reaches the filter. A tick on the first clock edge after `raw_in` changes therefore does not count toward the 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-clock strobe every millisecond |
| raw_in | input | 1 | Unsynchronized push-button input |
| mode_sel | input | 2 | Trigger kind: 00 rising, 01 falling, 10 high, 11 low |
| level_out | output | 1 | Filtered input level |
| stat_pull_en | output | 1 | Pull-down enable for the open-drain status pin, high while the filtered level is low |
| wake_evt | output | 1 | Wakeup event: a pulse in edge modes, a level in level modes |

## Verification
The assertions check on every cycle that the filtered level moves only on an edge that carries a tick and that the status enable follows the level in the opposite direction. They also check that an edge-mode event lasts one cycle and coincides with a matching change of level, and that a level-mode event tracks the level. The exact count of 32 ticks, the restart of the count after glitches of every length from 1 to 31 ticks, and the two-clock synchronizer delay can only be shown by the bench. It sweeps all four modes and both directions of change, and counts the ticks up to each change of `level_out`.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
   typedef enum logic [1:0] {
      TRIG_RISE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_HIGH = 2'b10,
      TRIG_LOW  = 2'b11
   } trig_mode_e;
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wkf_stable.sv
module wkf_stable #(
   parameter int   TICKS   = 32,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sample,
   output logic level
);
   localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= RST_VAL;
         cnt   <= '0;
      end else if (sample == level) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt == LAST) begin
            level <= sample;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wkf_detect.sv
module wkf_detect #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              level,
   input  wkf_pkg::trig_mode_e mode,
   output logic              evt
);
   import wkf_pkg::*;

   logic prev;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= level;
   end

   assign rise = level & ~prev;
   assign fall = ~level & prev;

   always_comb begin
      unique case (mode)
         TRIG_RISE: evt = rise;
         TRIG_FALL: evt = fall;
         TRIG_HIGH: evt = level;
         TRIG_LOW:  evt = ~level;
      endcase
   end
endmodule

// File: rtl/wake_deglitch.sv
module wake_deglitch #(
   parameter int   SYNC_STAGES  = 2,
   parameter int   STABLE_TICKS = 32,
   parameter logic RESET_LEVEL  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1ms,
   input  logic       raw_in,
   input  logic [1:0] mode_sel,
   output logic       level_out,
   output logic       stat_pull_en,
   output logic       wake_evt
);
   import wkf_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_deglitch: SYNC_STAGES must be at least 2");
   end
   if (STABLE_TICKS < 2) begin : g_bad_ticks
      $error("wake_deglitch: STABLE_TICKS must be at least 2");
   end

   logic synced;
   logic filt;

   wkf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RESET_LEVEL)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (synced)
   );

   wkf_stable #(.TICKS(STABLE_TICKS), .RST_VAL(RESET_LEVEL)) u_stable (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1ms),
      .sample (synced),
      .level  (filt)
   );

   wkf_detect #(.RST_VAL(RESET_LEVEL)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .level (filt),
      .mode  (trig_mode_e'(mode_sel)),
      .evt   (wake_evt)
   );

   assign level_out    = filt;
   assign stat_pull_en = ~filt;
endmodule

// File: rtl/wake_deglitch_chk.sv
module wake_deglitch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1ms,
   input logic [1:0] mode_sel,
   input logic       level_out,
   input logic       stat_pull_en,
   input logic       wake_evt
);
   p_level_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != $past(level_out)) |-> $past(tick_1ms));

   p_pull_rose_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level_out) |-> !stat_pull_en);

   p_pull_fell_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(level_out) |-> stat_pull_en);

   p_rise_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00 && wake_evt) |-> (level_out && !$past(level_out)));

   p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00 && wake_evt) |=> (!wake_evt || mode_sel != 2'b00));

   p_fall_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b01 && wake_evt) |-> (!level_out && $past(level_out)));

   p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b01 && wake_evt) |=> (!wake_evt || mode_sel != 2'b01));

   p_high_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b10) |-> (wake_evt == level_out));

   p_low_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b11) |-> (wake_evt == !level_out));
endmodule

bind wake_deglitch wake_deglitch_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_1ms     (tick_1ms),
   .mode_sel     (mode_sel),
   .level_out    (level_out),
   .stat_pull_en (stat_pull_en),
   .wake_evt     (wake_evt)
);

// File: tb/wake_deglitch_tb.sv
module wake_deglitch_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NTICK      = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1ms = 1'b0;
   logic       raw_in = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       level_out;
   logic       stat_pull_en;
   logic       wake_evt;

   int total = 0;
   int bad   = 0;
   logic cur = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_deglitch u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_1ms     (tick_1ms),
      .raw_in       (raw_in),
      .mode_sel     (mode_sel),
      .level_out    (level_out),
      .stat_pull_en (stat_pull_en),
      .wake_evt     (wake_evt)
   );

   function automatic logic exp_evt(input int m, input logic lvl, input logic flip_now);
      case (m)
         0:       return flip_now & lvl;
         1:       return flip_now & ~lvl;
         2:       return lvl;
         default: return ~lvl;
      endcase
   endfunction

   function automatic string mode_tag(input int m);
      case (m)
         0:       return "R5";
         1:       return "R6";
         2:       return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // check all three outputs against an expected level
   task automatic chk_all(input int m, input logic el, input logic flip_now, input string ltag);
      chk(level_out, el, ltag);
      chk(stat_pull_en, ~el, "R4");
      chk(wake_evt, exp_evt(m, el, flip_now), mode_tag(m));
   endtask

   // change raw to v, then issue ticks until level flips on the 32nd
   task automatic transition(input logic v, input int m, input bit sync_probe);
      raw_in = v;
      if (sync_probe) begin
         tick_1ms = 1'b1;           // tick on first edge: not counted (R9)
         @(negedge clk);
         tick_1ms = 1'b0;
         chk(level_out, ~v, "R9");
         idle(2);
      end else begin
         idle(3);
      end
      for (int k = 1; k <= NTICK; k++) begin
         tick_1ms = 1'b1;
         @(negedge clk);
         tick_1ms = 1'b0;
         chk_all(m, (k == NTICK) ? v : ~v, k == NTICK, (sync_probe && k == NTICK) ? "R9" : "R1");
         @(negedge clk);
         chk_all(m, (k == NTICK) ? v : ~v, 1'b0, "R1");
         idle(2);
      end
   endtask

   // disagreement of n ticks, then return to the accepted value
   task automatic glitch(input int n, input int m);
      raw_in = ~cur;
      idle(3);
      for (int k = 0; k < n; k++) begin
         tick_1ms = 1'b1;
         @(negedge clk);
         tick_1ms = 1'b0;
         chk_all(m, cur, 1'b0, "R2");
         idle(3);
      end
      raw_in = cur;
      idle(4);
      chk_all(m, cur, 1'b0, "R2");
   endtask

   task automatic run_all();
      idle(3);
      chk(level_out, 1'b0, "R3");
      chk(stat_pull_en, 1'b1, "R3");
      chk(wake_evt, 1'b0, "R3");
      rst_n = 1'b1;
      @(negedge clk);
      chk(level_out, 1'b0, "R3");
      chk(stat_pull_en, 1'b1, "R3");
      chk(wake_evt, 1'b0, "R3");
      for (int m = 0; m < 4; m++) begin
         mode_sel = 2'(m);
         @(negedge clk);
         chk_all(m, cur, 1'b0, mode_tag(m));
         transition(~cur, m, 1'b1);
         cur = ~cur;
         for (int n = 1; n < NTICK; n++) begin
            glitch(n, m);
            transition(~cur, m, 1'b0);   // full count after restart (R2)
            cur = ~cur;
         end
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
         end
      join_any
      disable fork;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule